// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the code-prefetch front end of a 16-bit processor that has a byte-wide bus. While there is room, it keeps asking the bus for code bytes at the current prefetch pointer. Each byte that comes back goes into a four-entry FIFO. The execution side takes bytes from the FIFO one at a time. With each read it says whether the byte opens a new instruction or continues the current one. One clock later the block reports a two-bit queue status and the byte that was taken.

A flush clears the queue and reloads the prefetch pointer from a new segment and offset. The same command can also install up to four initial bytes. When it does, the pointer skips past those bytes. A code fetch that is already on the bus when a flush arrives runs to completion, but its byte is thrown away.

Prefetching stops while the queue is full. After a byte is read from a full queue, two idle clocks always pass before the next fetch begins.

Top module: `pfq_top`

## Requirements
- R1: The queue holds at most four bytes, and reads return bytes in the order they were fetched.
- R2: When `rd_req` is high, the queue is not empty and no flush is requested, `rd_ack` is high in that same cycle and `rd_byte` carries the oldest byte. That byte leaves the queue at the clock edge.
- R3: A read request against an empty queue gets no `rd_ack` and consumes nothing. The execution side waits until a byte arrives.
- R4: While the queue holds four bytes and no fetch is in progress, `fetch_req` stays low.
- R5: After a read from a full queue (cycle C0), `fetch_req` is low in C1 and C2. It rises in C3 if no flush intervenes.
- R6: The status is registered and describes the previous cycle. `qs_code` uses 2'b00 for no read, 2'b01 for a first byte, 2'b11 for a subsequent byte and 2'b10 for a flush. `qs_byte` carries the byte read, or 0 when no byte was read.
- R7: A flush empties the queue and takes priority over a read in the same cycle. If a fetch is in progress, it keeps `fetch_req` high until `fetch_done`, and its byte is discarded.
- R8: A flush with `preload_cnt` = n (values above 4 are treated as 4) loads n bytes, lowest byte of `preload_bytes` first. The next fetch address becomes segment*16 + offset + n.
- R9: `fetch_addr` = (segment*16 + offset) mod 2^20. The offset advances by one for each byte kept and wraps at 16 bits.
- R10: `fetch_req`, once raised, stays high with a stable `fetch_addr` until a cycle with `fetch_done` high.
- R11: Reset empties the queue, lowers `fetch_req` and sets `qs_code` to none. The first fetch, at FFFF:0000 by default, starts at the first edge after reset is released.
- R12: No fetch starts on a flush edge. Otherwise a new fetch starts at the edge that ends the previous one (or at any idle edge) when no resume gap is pending and the queue, after that edge's reads and writes, holds fewer than four bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_req | input | 1 | Flush the queue and reload the prefetch pointer |
| flush_seg | input | 16 | New code segment |
| flush_off | input | 16 | New code offset |
| preload_cnt | input | 3 | Number of bytes to install on flush |
| preload_bytes | input | 32 | Bytes to install, lowest byte first |
| rd_req | input | 1 | Execution side requests a byte |
| rd_first | input | 1 | Requested byte starts an instruction |
| rd_ack | output | 1 | Byte delivered this cycle |
| rd_byte | output | 8 | Delivered byte |
| qs_code | output | 2 | Queue status for the previous cycle |
| qs_byte | output | 8 | Byte read in the previous cycle |
| fetch_req | output | 1 | Code fetch in progress |
| fetch_addr | output | 20 | Physical fetch address |
| fetch_done | input | 1 | Bus completes the fetch this cycle |
| fetch_data | input | 8 | Fetched byte, valid with fetch_done |

## Verification
A wrong occupancy count shows up within one cycle at `fetch_req`: either a fetch starts while four bytes are held, or an expected fetch is missing. A wrong pointer shows up as an out-of-order `rd_byte` on the next read. A stale discard flag shows up as a byte from the old address after a flush. A wrong resume counter moves the rising edge of `fetch_req` away from the third cycle after a read from a full queue. Because the reported status lags by one clock, a wrong status code or byte appears exactly one cycle after the read that caused it.

// File: rtl/pfq_pkg.sv
// Shared types and helpers for the prefetch queue.
// Assumes real-mode style addressing: segment*16 + offset in 20 bits.
package pfq_pkg;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

    // Physical address from segment and offset, wrapping at 1 MB.
    function automatic logic [19:0] pfq_phys(input logic [15:0] seg, input logic [15:0] off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction

endpackage

// File: rtl/pfq_store.sv
// Byte FIFO of DEPTH entries with bulk load.
// A load replaces the contents with load_cnt bytes (lowest byte first) and
// overrides push and pop in the same cycle. The caller never pushes when full.
module pfq_store #(
    parameter  int DEPTH = 4,
    parameter  int W     = 8,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CW-1:0]      load_cnt,
    input  logic [DEPTH*W-1:0] load_data,
    input  logic               push,
    input  logic [W-1:0]       push_data,
    input  logic               pop,
    output logic [W-1:0]       head,
    output logic [CW-1:0]      count,
    output logic               empty,
    output logic               full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;

    // Advance a ring pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Per-entry storage: bulk load or single write at the tail.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (load)
                mem[i] <= load_data[i*W +: W];
            else if (push && wr_ptr == PW'(i))
                mem[i] <= push_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (load) begin
            rd_ptr <= '0;
            wr_ptr <= (load_cnt == CW'(DEPTH)) ? '0 : PW'(load_cnt);
            count  <= load_cnt;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
// Prefetch pointer and bus request side.
// Holds fetch_req with a latched address until fetch_done. A flush during a
// fetch marks it for discard. A read from a full queue blocks new fetches
// for GAP clocks. Assumes the caller supplies 'room' from the post-edge fill.
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter  int          GAP     = 2,
    parameter  logic [15:0] RST_SEG = 16'hFFFF,
    parameter  logic [15:0] RST_OFF = 16'h0000,
    localparam int          GW      = (GAP < 2) ? 1 : $clog2(GAP)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [15:0] new_seg,
    input  logic [15:0] new_off,
    input  logic [15:0] skip,
    input  logic        fetch_done,
    input  logic        pop_full,
    input  logic        room,
    output logic        accept,
    output logic        fetch_req,
    output logic [19:0] fetch_addr
);
    logic [15:0]   seg, off, off_cur;
    logic          busy, discard, done_ev, start;
    logic [GW-1:0] gap;

    // Fetch completion, kept-byte detection and start decision.
    always_comb begin
        done_ev = busy && fetch_done;
        accept  = done_ev && !discard && !flush;
        off_cur = accept ? off + 16'd1 : off;
        start   = !flush && (!busy || done_ev) && (gap == '0) && !pop_full && room;
    end

    // Pointer, request, discard and resume-gap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg        <= RST_SEG;
            off        <= RST_OFF;
            busy       <= 1'b0;
            discard    <= 1'b0;
            gap        <= '0;
            fetch_addr <= '0;
        end else if (flush) begin
            seg <= new_seg;
            off <= new_off + skip;
            gap <= '0;
            if (busy && !fetch_done) begin
                discard <= 1'b1;
            end else begin
                busy    <= 1'b0;
                discard <= 1'b0;
            end
        end else begin
            off <= off_cur;
            if (start) begin
                busy       <= 1'b1;
                discard    <= 1'b0;
                fetch_addr <= pfq_phys(seg, off_cur);
            end else if (done_ev) begin
                busy    <= 1'b0;
                discard <= 1'b0;
            end
            if (pop_full)
                gap <= GW'(GAP - 1);
            else if (gap != '0)
                gap <= gap - 1'b1;
        end
    end

    assign fetch_req = busy;
endmodule

// File: rtl/pfq_status.sv
// Registered queue status: reports the previous cycle's read or flush.
// Flush has priority. The byte field is zero when no byte was read.
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       pop,
    input  logic       first,
    input  logic [7:0] byte_in,
    output logic [1:0] qs_code,
    output logic [7:0] qs_byte
);
    qstat_e code_q;

    // Capture this cycle's queue operation for report next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= QS_NONE;
            qs_byte <= '0;
        end else if (flush) begin
            code_q  <= QS_FLUSH;
            qs_byte <= '0;
        end else if (pop) begin
            code_q  <= first ? QS_FIRST : QS_NEXT;
            qs_byte <= byte_in;
        end else begin
            code_q  <= QS_NONE;
            qs_byte <= '0;
        end
    end

    assign qs_code = code_q;
endmodule

// File: rtl/pfq_top.sv
// Instruction prefetch queue top.
// Connects the byte store, the fetch side and the status register. Reads
// are acknowledged combinationally from the head. Flush beats read.
module pfq_top #(
    parameter  int          DEPTH      = 4,
    parameter  int          RESUME_GAP = 2,
    parameter  logic [15:0] RESET_SEG  = 16'hFFFF,
    parameter  logic [15:0] RESET_OFF  = 16'h0000,
    localparam int          CW         = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_req,
    input  logic [15:0]        flush_seg,
    input  logic [15:0]        flush_off,
    input  logic [CW-1:0]      preload_cnt,
    input  logic [DEPTH*8-1:0] preload_bytes,
    input  logic               rd_req,
    input  logic               rd_first,
    output logic               rd_ack,
    output logic [7:0]         rd_byte,
    output logic [1:0]         qs_code,
    output logic [7:0]         qs_byte,
    output logic               fetch_req,
    output logic [19:0]        fetch_addr,
    input  logic               fetch_done,
    input  logic [7:0]         fetch_data
);
    logic [CW-1:0] count, pl_n;
    logic          q_empty, q_full, pop, accept, room;
    logic [CW:0]   fill_after;

    // Read acceptance, preload clamp and post-edge room.
    always_comb begin
        pop        = rd_req && !q_empty && !flush_req;
        pl_n       = (preload_cnt > CW'(DEPTH)) ? CW'(DEPTH) : preload_cnt;
        fill_after = (CW+1)'(count) + (CW+1)'(accept) - (CW+1)'(pop);
        room       = fill_after < (CW+1)'(DEPTH);
    end

    pfq_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk(clk), .rst_n(rst_n),
        .load(flush_req), .load_cnt(pl_n), .load_data(preload_bytes),
        .push(accept), .push_data(fetch_data), .pop(pop),
        .head(rd_byte), .count(count), .empty(q_empty), .full(q_full)
    );

    pfq_fetch #(.GAP(RESUME_GAP), .RST_SEG(RESET_SEG), .RST_OFF(RESET_OFF)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .flush(flush_req), .new_seg(flush_seg), .new_off(flush_off),
        .skip(16'(pl_n)), .fetch_done(fetch_done),
        .pop_full(pop && q_full), .room(room), .accept(accept),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    pfq_status u_status (
        .clk(clk), .rst_n(rst_n),
        .flush(flush_req), .pop(pop), .first(rd_first), .byte_in(rd_byte),
        .qs_code(qs_code), .qs_byte(qs_byte)
    );

    assign rd_ack = pop;
endmodule

// File: rtl/pfq_checker.sv
// Temporal checks on the prefetch queue, bound into pfq_top.
module pfq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        flush_req,
    input logic        rd_req,
    input logic        rd_first,
    input logic        rd_ack,
    input logic [7:0]  rd_byte,
    input logic [1:0]  qs_code,
    input logic [7:0]  qs_byte,
    input logic        fetch_req,
    input logic [19:0] fetch_addr,
    input logic        fetch_done,
    input logic        q_full,
    input logic        q_empty
);
    assert_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (rd_req && !q_empty));

    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && q_empty && !flush_req) |=> (qs_code == 2'b00));

    assert_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !fetch_req && !rd_ack && !flush_req) |=> !fetch_req);

    assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && rd_ack && !fetch_req) |=> !fetch_req ##1 !fetch_req);

    assert_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && rd_first) |=> (qs_code == 2'b01 && qs_byte == $past(rd_byte)));

    assert_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_first) |=> (qs_code == 2'b11));

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (qs_code == 2'b10 && qs_byte == 8'h00));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_done) |=> (fetch_req && $stable(fetch_addr)));
endmodule

bind pfq_top pfq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .flush_req(flush_req),
    .rd_req(rd_req), .rd_first(rd_first), .rd_ack(rd_ack), .rd_byte(rd_byte),
    .qs_code(qs_code), .qs_byte(qs_byte),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
    .q_full(q_full), .q_empty(q_empty)
);

// File: tb/sim_pfq_top.sv
// Bench: cycle model of the requirements, a four-clock bus responder,
// directed corner cases and seeded random traffic.
module sim_pfq_top;
    localparam int BUS_LEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_req = 1'b0;
    logic [15:0] flush_seg = '0, flush_off = '0;
    logic [2:0]  preload_cnt = '0;
    logic [31:0] preload_bytes = '0;
    logic        rd_req = 1'b0, rd_first = 1'b0;
    logic        rd_ack, fetch_req, fetch_done = 1'b0;
    logic [7:0]  rd_byte, qs_byte, fetch_data = '0;
    logic [1:0]  qs_code;
    logic [19:0] fetch_addr;

    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    pfq_top u0 (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .flush_seg(flush_seg),
        .flush_off(flush_off), .preload_cnt(preload_cnt), .preload_bytes(preload_bytes),
        .rd_req(rd_req), .rd_first(rd_first), .rd_ack(rd_ack), .rd_byte(rd_byte),
        .qs_code(qs_code), .qs_byte(qs_byte), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_done(fetch_done), .fetch_data(fetch_data)
    );

    // Reference model state
    logic [7:0]  mq[$];
    logic        m_busy = 0, m_disc = 0;
    int          m_age = 0, m_gap = 0;
    logic [15:0] m_seg = 16'hFFFF, m_off = 16'h0000;
    logic [19:0] m_addr = '0;
    logic [1:0]  m_qs = 2'b00;
    logic [7:0]  m_qsb = '0;
    logic        seen_req, seen_ack;
    logic [7:0]  seen_byte;
    logic [19:0] seen_addr;

    function automatic logic [7:0] bdat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check, advance the model.
    task automatic step(input bit fl, input logic [15:0] s, input logic [15:0] o,
                        input int n, input logic [31:0] pd, input bit rd, input bit fi);
        bit done, ack, fullb, start;
        flush_req = fl; flush_seg = s; flush_off = o; preload_cnt = 3'(n);
        preload_bytes = pd; rd_req = rd; rd_first = fi;
        done = m_busy && (m_age == BUS_LEN - 1);
        fetch_done = done;
        fetch_data = bdat(m_addr);
        ack = rd && (mq.size() != 0) && !fl;
        #1;
        seen_req = fetch_req; seen_ack = rd_ack; seen_byte = rd_byte; seen_addr = fetch_addr;
        chk("R6 qs_code", 32'(qs_code), 32'(m_qs));
        chk("R6 qs_byte", 32'(qs_byte), 32'(m_qsb));
        chk("R10 fetch_req", 32'(fetch_req), 32'(m_busy));
        if (m_busy) chk("R9 fetch_addr", 32'(fetch_addr), 32'(m_addr));
        chk("R2 rd_ack", 32'(rd_ack), 32'(ack));
        if (ack) chk("R1 rd_byte", 32'(rd_byte), 32'(mq[0]));
        if (fl) begin m_qs = 2'b10; m_qsb = 0; end
        else if (ack) begin m_qs = fi ? 2'b01 : 2'b11; m_qsb = mq[0]; end
        else begin m_qs = 2'b00; m_qsb = 0; end
        if (fl) begin
            mq.delete();
            for (int i = 0; i < n; i++) mq.push_back(pd[i*8 +: 8]);
            m_seg = s; m_off = o + 16'(n); m_gap = 0;
            if (m_busy && !done) begin m_disc = 1; m_age++; end
            else begin m_busy = 0; m_disc = 0; m_age = 0; end
        end else begin
            fullb = (mq.size() == 4);
            if (ack) void'(mq.pop_front());
            if (done) begin
                if (!m_disc) begin mq.push_back(bdat(m_addr)); m_off++; end
                m_busy = 0; m_disc = 0; m_age = 0;
            end else if (m_busy) m_age++;
            start = !m_busy && (m_gap == 0) && !(ack && fullb) && (mq.size() < 4);
            if (start) begin
                m_busy = 1; m_age = 0;
                m_addr = {m_seg, 4'h0} + {4'h0, m_off};
            end
            if (ack && fullb) m_gap = 1; else if (m_gap != 0) m_gap--;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 16'h0, 16'h0, 0, 32'h0, 0, 0);
    endtask

    initial begin
        logic r1, r2, r3;
        void'($urandom(32'h5EED));
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset fetch_req", 32'(fetch_req), 0);
        chk("R11 reset qs_code", 32'(qs_code), 0);
        chk("R11 reset rd_ack", 32'(rd_ack), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0);
        chk("R11 first fetch addr", 32'(seen_addr), 32'h0);
        idle();
        chk("R11 first fetch at FFFF0", 32'(seen_addr), 32'hFFFF0);

        // R4: fill up, then fetching stops
        repeat (24) idle();
        chk("R4 full no fetch", 32'(seen_req), 0);

        // R8 + R5: preload four bytes, read them, check gap and pointer
        step(1, 16'h1234, 16'h0100, 4, 32'hA1B2C3D4, 0, 0);
        repeat (3) begin idle(); chk("R4 preload full no fetch", 32'(seen_req), 0); end
        step(0, 0, 0, 0, 0, 1, 1);
        chk("R8 preload byte0", 32'(seen_byte), 32'hD4);
        step(0, 0, 0, 0, 0, 1, 0); r1 = seen_req;
        chk("R8 preload byte1", 32'(seen_byte), 32'hC3);
        step(0, 0, 0, 0, 0, 1, 0); r2 = seen_req;
        step(0, 0, 0, 0, 0, 1, 0); r3 = seen_req;
        chk("R8 preload byte3", 32'(seen_byte), 32'hA1);
        chk("R5 gap cycle1", 32'(r1), 0);
        chk("R5 gap cycle2", 32'(r2), 0);
        chk("R5 resume cycle3", 32'(r3), 1);
        chk("R8 fetch after preload", 32'(seen_addr), 32'h12444);

        // R9 + R12: offset wrap and back-to-back fetch
        repeat (6) idle();
        step(1, 16'h1000, 16'hFFFF, 0, 0, 0, 0);
        idle(); idle();
        chk("R12 start after flush", 32'(seen_req), 1);
        chk("R9 first addr", 32'(seen_addr), 32'h1FFFF);
        repeat (3) idle();
        idle();
        chk("R12 back to back", 32'(seen_req), 1);
        chk("R9 offset wrap", 32'(seen_addr), 32'h10000);
        repeat (6) idle();
        step(1, 16'hFFFF, 16'hFFF8, 0, 0, 0, 0);
        idle(); idle();
        chk("R9 20-bit wrap", 32'(seen_addr), 32'h0FFE8);

        // R7 + R3: flush during an in-flight fetch discards its byte
        repeat (6) idle();
        step(1, 16'h2000, 16'h0010, 0, 0, 0, 0);
        idle(); idle(); idle();
        step(1, 16'h3000, 16'h0000, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 1);
        chk("R3 empty read stalls", 32'(seen_ack), 0);
        for (int k = 0; k < 20 && !seen_ack; k++) step(0, 0, 0, 0, 0, 1, 1);
        chk("R7 discarded old byte", 32'(seen_byte), 32'(bdat(20'h30000)));

        // Seeded random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            bit fl = ($urandom % 100) < 3;
            step(fl, 16'($urandom), 16'($urandom), int'($urandom % 5), $urandom,
                 ($urandom % 100) < 55, ($urandom % 100) < 30);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        #800000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule